// File: doc/BRIEF.md
# Halfword Scratch-Pad Register File with Byte Parity

This block is a small local register file for a processor datapath. It holds a set of halfword entries (sixteen by default), each made of a high byte and a low byte, and is used for addresses, counts and other working values. Each stored byte carries one parity bit beside its data bits. The block generates the parity as the byte is written and checks it again as the byte is read.

A read takes only the entry index. Both bytes of the selected entry, each with its parity bit, appear on the read outputs combinationally, and the same cycle gets a per-byte parity-error flag. A write takes the entry index, one data byte and a strobe that names the half to be written, so the two halves of an entry are updated on their own. Raising both strobes together is a protocol misuse. The block then writes the same byte into both halves and flags the misuse for one cycle. Writes take effect on the rising clock edge.

Top module: `hwrf_regfile`

## Requirements
- R1: After reset, every byte of every entry reads as 9'h100: data bits zero and parity bit (bit 8) set.
- R2: Each read byte has its parity in bit 8 and its data in bits 7:0. The parity is odd by default, so the nine bits hold an odd number of ones.
- R3: The read outputs `rd_hi` and `rd_lo` follow the `sel` input within the same cycle, with no clock edge in between.
- R4: When `wr_lo` is high and `wr_hi` is low at a rising edge, the low byte of entry `sel` becomes `wdata` with its parity, and the high byte of that entry keeps its value.
- R5: When `wr_hi` is high and `wr_lo` is low at a rising edge, the high byte of entry `sel` becomes `wdata` with its parity, and the low byte of that entry keeps its value.
- R6: When both strobes are high at a rising edge, both bytes of entry `sel` become `wdata` with its parity. `proto_err` is high for exactly the cycle that follows that edge and is low after every other edge.
- R7: With neither strobe high, no entry changes at any edge, whatever `sel` and `wdata` hold.
- R8: A write to one entry leaves every other entry unchanged.
- R9: `perr_hi` and `perr_lo` are high only when the byte being read fails the parity rule of R2. Storage is filled only through the write port, so both flags stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 4 | Entry index for both read and write (value k addresses entry k) |
| wdata | input | 8 | Data byte to write |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_lo | input | 1 | Write strobe for the low byte |
| rd_hi | output | 9 | High byte of the selected entry, {parity, data} |
| rd_lo | output | 9 | Low byte of the selected entry, {parity, data} |
| perr_hi | output | 1 | Parity mismatch on `rd_hi` |
| perr_lo | output | 1 | Parity mismatch on `rd_lo` |
| proto_err | output | 1 | Both strobes were high at the previous edge |

## Verification
The assertions assume that `sel`, `wdata` and the strobes are steady around each rising edge, and that the strobes are low while reset is held. They also assume that `sel` is an index below the entry count. The write checks compare what is read one cycle later only when `sel` has not moved, so they rely on the bench holding the index across the edge it writes on. The bench changes every input at the falling edge, releases reset with the strobes low, and uses only indices 0 to 15.

// File: rtl/hwrf_pkg.sv
`timescale 1ns/1ps
package hwrf_pkg;
   // lane numbering inside one halfword entry
   typedef enum logic {
      LANE_LO = 1'b0,
      LANE_HI = 1'b1
   } lane_e;

   localparam int unsigned NUM_LANES = 2;

   // value of one stored byte after reset: zero data, parity set for odd rule
   function automatic logic [63:0] rst_word(input int unsigned data_w, input bit odd);
      logic [63:0] v;
      v = '0;
      v[data_w] = odd;
      return v;
   endfunction
endpackage

// File: rtl/hwrf_par_gen.sv
`timescale 1ns/1ps
module hwrf_par_gen #(
   parameter int unsigned DATA_W     = 8,
   parameter bit          ODD_PARITY = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W:0]   dout
);
   logic par;

   generate
      if (ODD_PARITY) begin : g_odd
         assign par = ~(^din);
      end else begin : g_even
         assign par = ^din;
      end
   endgenerate

   assign dout = {par, din};
endmodule

// File: rtl/hwrf_lane.sv
`timescale 1ns/1ps
module hwrf_lane #(
   parameter int unsigned ENTRIES    = 16,
   parameter int unsigned DATA_W     = 8,
   parameter bit          ODD_PARITY = 1'b1,
   localparam int unsigned BYTE_W    = DATA_W + 1,
   localparam int unsigned SEL_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [SEL_W-1:0]          wsel,
   input  logic [BYTE_W-1:0]         wbyte,
   output logic [ENTRIES*BYTE_W-1:0] q_flat
);
   import hwrf_pkg::*;

   localparam logic [63:0]       RST_W   = rst_word(DATA_W, ODD_PARITY);
   localparam logic [BYTE_W-1:0] RST_VAL = RST_W[BYTE_W-1:0];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic [BYTE_W-1:0] q;
      logic              hit;

      assign hit = we && (wsel == SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= RST_VAL;
         end else if (hit) begin
            q <= wbyte;
         end
      end

      assign q_flat[i*BYTE_W +: BYTE_W] = q;
   end
endmodule

// File: rtl/hwrf_rd_port.sv
`timescale 1ns/1ps
module hwrf_rd_port #(
   parameter int unsigned ENTRIES    = 16,
   parameter int unsigned DATA_W     = 8,
   parameter bit          ODD_PARITY = 1'b1,
   localparam int unsigned BYTE_W    = DATA_W + 1,
   localparam int unsigned SEL_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [SEL_W-1:0]          sel,
   input  logic [ENTRIES*BYTE_W-1:0] q_flat,
   output logic [BYTE_W-1:0]         rd_byte,
   output logic                      perr
);
   import hwrf_pkg::*;

   localparam logic [63:0]       RST_W   = rst_word(DATA_W, ODD_PARITY);
   localparam logic [BYTE_W-1:0] RST_VAL = RST_W[BYTE_W-1:0];

   always_comb begin
      rd_byte = RST_VAL;
      for (int k = 0; k < ENTRIES; k++) begin
         if (sel == SEL_W'(k)) begin
            rd_byte = q_flat[k*BYTE_W +: BYTE_W];
         end
      end
   end

   generate
      if (ODD_PARITY) begin : g_chk_odd
         assign perr = ~(^rd_byte);
      end else begin : g_chk_even
         assign perr = ^rd_byte;
      end
   endgenerate
endmodule

// File: rtl/hwrf_regfile.sv
`timescale 1ns/1ps
module hwrf_regfile #(
   parameter int unsigned ENTRIES    = 16,
   parameter int unsigned DATA_W     = 8,
   parameter bit          ODD_PARITY = 1'b1,
   localparam int unsigned BYTE_W    = DATA_W + 1,
   localparam int unsigned SEL_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_hi,
   input  logic              wr_lo,
   output logic [BYTE_W-1:0] rd_hi,
   output logic [BYTE_W-1:0] rd_lo,
   output logic              perr_hi,
   output logic              perr_lo,
   output logic              proto_err
);
   import hwrf_pkg::*;

   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("hwrf_regfile: ENTRIES must be at least 2");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("hwrf_regfile: DATA_W must be 1..32");
   end

   logic [BYTE_W-1:0]         wbyte;
   logic [NUM_LANES-1:0]      lane_we;
   logic [BYTE_W-1:0]         lane_rd   [NUM_LANES];
   logic [NUM_LANES-1:0]      lane_perr;
   logic                      proto_q;

   hwrf_par_gen #(
      .DATA_W     (DATA_W),
      .ODD_PARITY (ODD_PARITY)
   ) u_pgen (
      .din  (wdata),
      .dout (wbyte)
   );

   assign lane_we[LANE_LO] = wr_lo;
   assign lane_we[LANE_HI] = wr_hi;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic [ENTRIES*BYTE_W-1:0] q_flat;

      hwrf_lane #(
         .ENTRIES    (ENTRIES),
         .DATA_W     (DATA_W),
         .ODD_PARITY (ODD_PARITY)
      ) u_store (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (lane_we[g]),
         .wsel   (sel),
         .wbyte  (wbyte),
         .q_flat (q_flat)
      );

      hwrf_rd_port #(
         .ENTRIES    (ENTRIES),
         .DATA_W     (DATA_W),
         .ODD_PARITY (ODD_PARITY)
      ) u_rd (
         .sel     (sel),
         .q_flat  (q_flat),
         .rd_byte (lane_rd[g]),
         .perr    (lane_perr[g])
      );
   end

   // one-cycle flag after an edge that saw both strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         proto_q <= 1'b0;
      end else begin
         proto_q <= wr_hi & wr_lo;
      end
   end

   assign rd_lo     = lane_rd[LANE_LO];
   assign rd_hi     = lane_rd[LANE_HI];
   assign perr_lo   = lane_perr[LANE_LO];
   assign perr_hi   = lane_perr[LANE_HI];
   assign proto_err = proto_q;
endmodule

// File: rtl/hwrf_chk.sv
`timescale 1ns/1ps
module hwrf_chk #(
   parameter int unsigned ENTRIES    = 16,
   parameter int unsigned DATA_W     = 8,
   parameter bit          ODD_PARITY = 1'b1,
   localparam int unsigned BYTE_W    = DATA_W + 1,
   localparam int unsigned SEL_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SEL_W-1:0]  sel,
   input logic [DATA_W-1:0] wdata,
   input logic              wr_hi,
   input logic              wr_lo,
   input logic [BYTE_W-1:0] rd_hi,
   input logic [BYTE_W-1:0] rd_lo,
   input logic              perr_hi,
   input logic              perr_lo,
   input logic              proto_err
);
   function automatic logic [BYTE_W-1:0] enc(input logic [DATA_W-1:0] d);
      return {(ODD_PARITY ? ~(^d) : ^d), d};
   endfunction

   // R2
   rd_lo_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (^rd_lo) == ODD_PARITY);

   // R2
   rd_hi_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (^rd_hi) == ODD_PARITY);

   // R4
   lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> (sel != $past(sel)) ||
                            (rd_lo == enc($past(wdata)) && rd_hi == $past(rd_hi)));

   // R5
   hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> (sel != $past(sel)) ||
                            (rd_hi == enc($past(wdata)) && rd_lo == $past(rd_lo)));

   // R6
   dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && wr_lo) |=> proto_err && ((sel != $past(sel)) ||
                           (rd_hi == enc($past(wdata)) && rd_lo == enc($past(wdata)))));

   // R6
   no_proto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hi && wr_lo) |=> !proto_err);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hi && !wr_lo) |=> (sel != $past(sel)) || ($stable(rd_hi) && $stable(rd_lo)));

   // R9
   no_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_hi && !perr_lo);
endmodule

bind hwrf_regfile hwrf_chk #(
   .ENTRIES    (ENTRIES),
   .DATA_W     (DATA_W),
   .ODD_PARITY (ODD_PARITY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel       (sel),
   .wdata     (wdata),
   .wr_hi     (wr_hi),
   .wr_lo     (wr_lo),
   .rd_hi     (rd_hi),
   .rd_lo     (rd_lo),
   .perr_hi   (perr_hi),
   .perr_lo   (perr_lo),
   .proto_err (proto_err)
);

// File: tb/tb_hwrf_regfile.sv
`timescale 1ns/1ps
module tb_hwrf_regfile;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] sel = '0;
   logic [7:0] wdata = '0;
   logic       wr_hi = 1'b0;
   logic       wr_lo = 1'b0;
   logic [8:0] rd_hi, rd_lo;
   logic       perr_hi, perr_lo, proto_err;

   int total = 0;
   int bad   = 0;

   logic [8:0] m_hi [16];
   logic [8:0] m_lo [16];

   always #10 clk = ~clk;   // 50 MHz

   hwrf_regfile dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wdata(wdata),
      .wr_hi(wr_hi), .wr_lo(wr_lo), .rd_hi(rd_hi), .rd_lo(rd_lo),
      .perr_hi(perr_hi), .perr_lo(perr_lo), .proto_err(proto_err)
   );

   // odd parity byte: bit 8 parity, bits 7:0 data (R2)
   function automatic logic [8:0] odd9(input logic [7:0] d);
      int n = 0;
      for (int b = 0; b < 8; b++) n += d[b];
      return {(n % 2 == 0), d};
   endfunction

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // read every entry and compare against the model (combinational read, R3)
   task automatic sweep(input string req);
      for (int e = 0; e < 16; e++) begin
         sel = 4'(e);
         #1;
         chk(req, rd_hi, m_hi[e]);
         chk(req, rd_lo, m_lo[e]);
         chk("R9", {7'b0, perr_hi, perr_lo}, 9'h0);
      end
   endtask

   task automatic wr(input logic [3:0] s, input logic [7:0] d, input logic h, input logic l);
      @(negedge clk);
      sel = s; wdata = d; wr_hi = h; wr_lo = l;
      @(negedge clk);
      if (h) m_hi[s] = odd9(d);
      if (l) m_lo[s] = odd9(d);
      chk("R6 flag", {8'b0, proto_err}, {8'b0, h & l});
      wr_hi = 1'b0; wr_lo = 1'b0;
   endtask

   task automatic t_reset;
      for (int e = 0; e < 16; e++) begin
         m_hi[e] = 9'h100;
         m_lo[e] = 9'h100;
      end
      sweep("R1");
      chk("R6 reset", {8'b0, proto_err}, 9'h0);
   endtask

   task automatic t_lo_only;
      wr(4'd3, 8'hA5, 1'b0, 1'b1);
      wr(4'd3, 8'h01, 1'b0, 1'b1);
      sel = 4'd3; #1;
      chk("R4 lo", rd_lo, 9'h001);
      chk("R4 hi kept", rd_hi, 9'h100);
      sweep("R4");
   endtask

   task automatic t_hi_only;
      wr(4'd3, 8'h7F, 1'b1, 1'b0);
      sel = 4'd3; #1;
      chk("R5 hi", rd_hi, 9'h07F);
      chk("R5 lo kept", rd_lo, 9'h001);
      wr(4'd0, 8'hFF, 1'b1, 1'b0);
      wr(4'd15, 8'h00, 1'b1, 1'b0);
      sweep("R5");
   endtask

   task automatic t_parity_patterns;
      logic [7:0] pats [6] = '{8'h00, 8'h80, 8'h03, 8'hFE, 8'h55, 8'hFF};
      for (int i = 0; i < 6; i++) begin
         wr(4'(8 + i), pats[i], 1'b0, 1'b1);
         wr(4'(8 + i), ~pats[i], 1'b1, 1'b0);
      end
      sel = 4'd9; #1;
      chk("R2 one bit", rd_lo, 9'h080);
      sel = 4'd13; #1;
      chk("R2 all ones", rd_lo, 9'h1FF);
      sweep("R2");
   endtask

   task automatic t_dual;
      wr(4'd6, 8'h3C, 1'b1, 1'b1);
      sel = 4'd6; #1;
      chk("R6 hi", rd_hi, 9'h13C);
      chk("R6 lo", rd_lo, 9'h13C);
      @(negedge clk);
      chk("R6 one cycle", {8'b0, proto_err}, 9'h0);
      sweep("R6");
   endtask

   task automatic t_idle;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         sel = 4'(i * 2); wdata = 8'(i * 37 + 5);
      end
      @(negedge clk);
      chk("R7 flag", {8'b0, proto_err}, 9'h0);
      sweep("R7");
   endtask

   task automatic t_isolation;
      wr(4'd5, 8'hC3, 1'b1, 1'b0);
      wr(4'd5, 8'h18, 1'b0, 1'b1);
      sel = 4'd4; #1;
      chk("R8 neighbour lo", rd_lo, 9'h100);
      sel = 4'd6; #1;
      chk("R8 neighbour hi", rd_hi, 9'h13C);
      sweep("R8");
   endtask

   task automatic t_comb_read;
      @(negedge clk);
      sel = 4'd5; #2;
      chk("R3 sel5", rd_hi, m_hi[5]);
      sel = 4'd3; #2;
      chk("R3 sel3", rd_hi, m_hi[3]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_lo_only();
      t_hi_only();
      t_parity_patterns();
      t_dual();
      t_idle();
      t_isolation();
      t_comb_read();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule